// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through first-level data cache and the second-level cache. It takes 8-byte stores from the processor so that a store miss costs no stall. Stores are gathered into four block-sized (32-byte) slots, and each slot carries a per-byte valid mask. When a store lands in a block that already waits in a slot, it is folded into that slot instead of using a new one. Slots leave the buffer in arrival order, one at a time, from the oldest slot. Each departure is a fixed-length write on the downstream port that carries the block address, the block data and a byte mask.

Before a read miss may go to the second level, the cache controller raises a flush request. The buffer then takes no new stores and empties itself. It answers with a one-cycle done pulse after the final downstream write ends, so no read can pass a pending write to the same location. The oldest slot goes downstream as soon as it exists, so it is never a merge target. A store to that block opens a fresh slot, which is written after the oldest one.

Top module: `merge_wbuf`

## Requirements
- R1: After reset, st_ready is 1 and dn_valid and flush_done are 0.
- R2: A store is taken in a cycle where st_valid and st_ready are both 1. st_ready is 1 exactly when no flush is in progress and fewer than four slots are occupied. The stall rule does not depend on whether the store could merge.
- R3: A taken store whose block address (st_addr[31:5]) matches an occupied slot other than the oldest one merges into that slot. The masks are ORed, the enabled bytes are overwritten, and no slot is added.
- R4: The oldest occupied slot is always in flight. A taken store that matches only that slot, or no slot at all, occupies a new slot at the tail.
- R5: Slots are written downstream in first-in first-out order. dn_valid rises in the cycle after a slot becomes the oldest while no write is running, and it stays high for exactly 15 cycles with dn_addr, dn_mask and dn_data stable. After that there is at least one idle cycle.
- R6: Store byte k (st_data[8k+7:8k], enabled by st_be[k]) goes to block byte 8*st_addr[4:3]+k. Block byte b is dn_data[8b+7:8b], and it is valid when dn_mask[b] is 1. dn_mask has a bit set for every byte that any store merged into the slot enabled. Each valid byte carries the value from the last store to write it.
- R7: A flush_req sampled while no flush is running starts a flush. st_ready is 0 from the next cycle until flush_done. flush_done is a one-cycle pulse in the cycle after the last dn_valid cycle that empties the buffer. If the buffer is already empty, it comes in the second cycle after the request cycle.
- R8: A flush_req during a flush in progress has no effect: exactly one flush_done pulse follows.
- R9: st_addr[2:0] is ignored, and a store presented with st_valid low changes nothing downstream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store presented |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | 32 | Store byte address, bits [2:0] ignored |
| st_data | input | 64 | Store data, byte k in bits [8k+7:8k] |
| st_be | input | 8 | Store byte enables |
| flush_req | input | 1 | Request to empty the buffer |
| flush_done | output | 1 | One-cycle pulse once the buffer is empty |
| dn_valid | output | 1 | Downstream write in progress |
| dn_addr | output | 27 | Block address of the downstream write |
| dn_data | output | 256 | Block data of the downstream write |
| dn_mask | output | 32 | Byte-valid mask of the downstream write |

## Verification
Directed sequences come first. A run of same-block stores separates merging into a younger slot from the required fresh allocation behind the in-flight slot. Back-to-back stores to distinct blocks show that the stall begins at exactly four slots. A flush with stores and a repeated request in flight separates a correct single done pulse from a duplicated or early one, and a flush of an empty buffer checks its fixed two-cycle answer. Constrained random traffic then aims at a small pool of blocks with random byte enables and junk low address bits, so merges, overlapping bytes and stalls interleave. Every downstream write is compared byte by byte with a bench model of the slots.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/wbuf_match.sv
module wbuf_match #(
  parameter int N    = 4,
  parameter int TAGW = 27,
  localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N-1:0][TAGW-1:0] tags,
  input  logic [N-1:0]          elig,
  input  logic [TAGW-1:0]       key,
  output logic                  hit,
  output logic [IW-1:0]         idx
);
  logic [N-1:0] hits;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hits[i] = elig[i] && (tags[i] == key);
  end

  assign hit = |hits;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++)
      if (hits[i]) idx = IW'(i);
  end

  // R3: the merge target is unique among younger slots
  p_single_match_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hits));
endmodule

// File: rtl/wbuf_ram.sv
module wbuf_ram #(
  parameter int DEPTH = 4,
  parameter int BYTES = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [BYTES-1:0]   wbe,
  input  logic [8*BYTES-1:0] wdata,
  input  logic               re,
  input  logic [AW-1:0]      raddr,
  output logic [8*BYTES-1:0] rdata
);
  import wbuf_pkg::*;

  byte_t [BYTES-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      for (int b = 0; b < BYTES; b++)
        if (wbe[b]) mem[waddr][b] <= wdata[8*b +: 8];
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/wbuf_drain.sv
module wbuf_drain #(
  parameter int LAT = 15,
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic pending,
  output logic busy,
  output logic start,
  output logic finish
);
  logic [CW-1:0] cnt;

  assign start  = pending && !busy;
  assign finish = busy && (cnt == CW'(LAT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (finish) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5: a write ends after its last latency cycle and leaves a gap
  p_write_len_r5: assert property (@(posedge clk) disable iff (rst)
    finish |=> !busy);
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf #(
  parameter int AW         = 32,
  parameter int BLK_BYTES  = 32,
  parameter int WORD_BYTES = 8,
  parameter int DEPTH      = 4,
  parameter int WR_LAT     = 15
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                st_valid,
  output logic                                st_ready,
  input  logic [AW-1:0]                       st_addr,
  input  logic [8*WORD_BYTES-1:0]             st_data,
  input  logic [WORD_BYTES-1:0]               st_be,
  input  logic                                flush_req,
  output logic                                flush_done,
  output logic                                dn_valid,
  output logic [AW-$clog2(BLK_BYTES)-1:0]     dn_addr,
  output logic [8*BLK_BYTES-1:0]              dn_data,
  output logic [BLK_BYTES-1:0]                dn_mask
);
  localparam int OFF_W  = $clog2(BLK_BYTES);
  localparam int WOFF_W = $clog2(WORD_BYTES);
  localparam int BA_W   = AW - OFF_W;
  localparam int WPB    = BLK_BYTES / WORD_BYTES;
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][BA_W-1:0] ent_addr;
  logic [BLK_BYTES-1:0]       ent_mask [DEPTH];
  logic [IDX_W-1:0]           head;
  logic [CNT_W-1:0]           count;
  logic                       flushing;

  logic [BA_W-1:0]      st_blk;
  logic [BLK_BYTES-1:0] lane_mask;
  logic [DEPTH-1:0]     elig;
  logic                 hit, alloc, st_fire, start, finish, done_now;
  logic [IDX_W-1:0]     hit_idx, tail, wr_idx;
  logic                 unused_low;

  assign unused_low = ^st_addr[WOFF_W-1:0];
  assign st_blk     = st_addr[AW-1:OFF_W];
  assign lane_mask  = BLK_BYTES'(st_be) << (st_addr[OFF_W-1:WOFF_W] * WORD_BYTES);
  assign st_ready   = !flushing && (count < CNT_W'(DEPTH));
  assign st_fire    = st_valid && st_ready;
  assign tail       = head + count[IDX_W-1:0];

  // younger slots only: the oldest one is always on its way out
  for (genvar i = 0; i < DEPTH; i++) begin : g_elig
    logic [IDX_W-1:0] rel;
    assign rel     = IDX_W'(i) - head;
    assign elig[i] = (rel != '0) && (CNT_W'(rel) < count);
  end

  wbuf_match #(.N(DEPTH), .TAGW(BA_W)) u_match (
    .clk(clk), .rst(rst), .tags(ent_addr), .elig(elig), .key(st_blk),
    .hit(hit), .idx(hit_idx));

  assign alloc  = st_fire && !hit;
  assign wr_idx = hit ? hit_idx : tail;

  wbuf_drain #(.LAT(WR_LAT)) u_drain (
    .clk(clk), .rst(rst), .pending(count != '0), .busy(dn_valid),
    .start(start), .finish(finish));

  wbuf_ram #(.DEPTH(DEPTH), .BYTES(BLK_BYTES)) u_ram (
    .clk(clk), .we(st_fire), .waddr(wr_idx), .wbe(lane_mask),
    .wdata({WPB{st_data}}), .re(start), .raddr(head), .rdata(dn_data));

  assign done_now = flushing && ((count == '0) || (finish && count == CNT_W'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      head       <= '0;
      count      <= '0;
      flushing   <= 1'b0;
      flush_done <= 1'b0;
    end else begin
      if (finish) head <= head + 1'b1;
      count      <= count + CNT_W'(alloc) - CNT_W'(finish);
      flush_done <= done_now;
      flushing   <= flushing ? !done_now : flush_req;
    end
  end

  always_ff @(posedge clk) begin
    if (st_fire) begin
      if (alloc) ent_addr[wr_idx] <= st_blk;
      ent_mask[wr_idx] <= hit ? (ent_mask[wr_idx] | lane_mask) : lane_mask;
    end
    if (start) begin
      dn_addr <= ent_addr[head];
      dn_mask <= ent_mask[head];
    end
  end

  // R2: occupancy never exceeds capacity
  p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  // R5: the downstream write holds address and mask for its whole length
  p_dn_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && $past(dn_valid)) |-> ($stable(dn_addr) && $stable(dn_mask)));
  // R7: done only with nothing buffered and nothing in flight
  p_flush_done_empty_r7: assert property (@(posedge clk) disable iff (rst)
    flush_done |-> (count == '0 && !dn_valid));
endmodule

// File: tb/tb_merge_wbuf.sv
`timescale 1ns/1ps
module tb_merge_wbuf;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         st_valid = 1'b0, flush_req = 1'b0;
  logic [31:0]  st_addr = '0;
  logic [63:0]  st_data = '0;
  logic [7:0]   st_be = '0;
  logic         st_ready, flush_done, dn_valid;
  logic [26:0]  dn_addr;
  logic [255:0] dn_data;
  logic [31:0]  dn_mask;

  merge_wbuf dut (.clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be), .flush_req(flush_req),
    .flush_done(flush_done), .dn_valid(dn_valid), .dn_addr(dn_addr),
    .dn_data(dn_data), .dn_mask(dn_mask));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [26:0]  m_addr [4];
  logic [31:0]  m_mask [4];
  logic [255:0] m_data [4];
  int m_n = 0, m_cnt = 0;
  bit m_busy = 0, m_flushing = 0, m_done = 0;

  function automatic logic [255:0] bytemask(input logic [31:0] m);
    logic [255:0] r;
    for (int b = 0; b < 32; b++) r[8*b +: 8] = {8{m[b]}};
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one cycle: check outputs, drive inputs, advance the model by one edge
  task automatic step(input bit sv, input logic [31:0] sa, input logic [63:0] sd,
                      input logic [7:0] sbe, input bit fr);
    bit exp_ready, acc, pop, start, done_now, hit;
    int j;
    logic [255:0] bm;
    @(negedge clk);
    exp_ready = !m_flushing && (m_n < 4);
    check(st_ready == exp_ready, "R2 R7", "st_ready", 256'(st_ready), 256'(exp_ready));
    check(dn_valid == m_busy, "R5", "dn_valid", 256'(dn_valid), 256'(m_busy));
    check(flush_done == m_done, "R7 R8", "flush_done", 256'(flush_done), 256'(m_done));
    if (m_busy && dn_valid) begin
      bm = bytemask(m_mask[0]);
      check(dn_addr == m_addr[0], "R4 R5", "dn_addr", 256'(dn_addr), 256'(m_addr[0]));
      check(dn_mask == m_mask[0], "R3 R6", "dn_mask", 256'(dn_mask), 256'(m_mask[0]));
      check((dn_data & bm) == (m_data[0] & bm), "R3 R6 R9", "dn_data",
            dn_data & bm, m_data[0] & bm);
    end
    st_valid = sv; st_addr = sa; st_data = sd; st_be = sbe; flush_req = fr;
    acc = sv && exp_ready;
    pop = m_busy && (m_cnt == 14);
    start = !m_busy && (m_n > 0);
    done_now = m_flushing && ((m_n == 0) || (pop && m_n == 1));
    if (acc) begin
      hit = 0; j = m_n;
      for (int i = 1; i < m_n; i++)
        if (m_addr[i] == sa[31:5]) begin hit = 1; j = i; end
      if (!hit) begin
        m_addr[j] = sa[31:5]; m_mask[j] = '0; m_data[j] = '0; m_n++;
      end
      for (int k = 0; k < 8; k++)
        if (sbe[k]) begin
          m_mask[j][sa[4:3]*8 + k] = 1'b1;
          m_data[j][(sa[4:3]*8 + k)*8 +: 8] = sd[8*k +: 8];
        end
    end
    if (pop) begin
      for (int i = 0; i < 3; i++) begin
        m_addr[i] = m_addr[i+1]; m_mask[i] = m_mask[i+1]; m_data[i] = m_data[i+1];
      end
      m_n--;
      m_busy = 0;
    end else if (start) begin
      m_busy = 1; m_cnt = 0;
    end else if (m_busy) m_cnt++;
    m_done = done_now;
    m_flushing = m_flushing ? !done_now : fr;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, $urandom, {$urandom, $urandom}, $urandom, 0);
  endtask

  task automatic store(input logic [26:0] blk, input logic [1:0] w, input logic [7:0] be);
    step(1, {blk, w, 3'($urandom)}, {$urandom, $urandom}, be, 0);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle state after reset
    check(st_ready == 1'b1 && dn_valid == 1'b0 && flush_done == 1'b0, "R1",
          "reset outputs", 256'({st_ready, dn_valid, flush_done}), 256'(3'b100));
    // R4 then R3: same block into the in-flight slot and then into a younger one
    store(27'h0000AA, 2'd0, 8'hFF);
    store(27'h0000AA, 2'd1, 8'h0F);
    store(27'h0000AA, 2'd2, 8'hF0);
    store(27'h000BBB, 2'd3, 8'h81);
    store(27'h0000AA, 2'd1, 8'h3C);
    idle(80);
    // R2: distinct blocks back to back, stall at four slots
    for (int i = 0; i < 7; i++) store(27'h100 + 27'(i), 2'(i), 8'hFF);
    idle(10);
    // R7 R8: flush with content, stores refused, repeated request ignored
    step(0, 0, 0, 0, 1);
    for (int i = 0; i < 5; i++) store(27'h200 + 27'(i), 2'd0, 8'hFF);
    step(0, 0, 0, 0, 1);
    idle(90);
    // R7: flush of an empty buffer
    step(0, 0, 0, 0, 1);
    idle(5);
    // random mix, R9 via junk low bits and presented-but-invalid stores
    for (int i = 0; i < 3000; i++) begin
      logic [26:0] blk = 27'h300 + 27'($urandom_range(0, 4));
      logic [7:0]  be = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom);
      step($urandom_range(0, 1) == 1, {blk, 5'($urandom)}, {$urandom, $urandom}, be,
           $urandom_range(0, 49) == 0);
    end
    step(0, 0, 0, 0, 1);
    idle(100);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule